// File: doc/BRIEF.md
# Coherence Directory Controller

This block is the ordering point for a set of private caches that share a memory level. It keeps a small, fully associative table. Each slot holds a line address, a flag that says whether one cache owns the line in a modified state, and a vector with one bit per cache that marks which caches hold a copy. The block takes one request per cycle from any cache: a read-for-copy, a write-for-ownership or an eviction notice. One cycle later it answers through several output groups:
- a grant to the requester, with the state the requester may install;
- forwarded read or write messages to the caches that currently hold the line;
- the id of the cache that must supply the data;
- a read request to the lower memory level;
- an invalidation aimed at every holder of a slot that was displaced to make room.

Data never passes through the block. A supplier id is emitted in place of data. When a line is already cached somewhere, a peer cache supplies it. Memory is read only when no slot tracks the line.

Top module: `coh_dir`

## Requirements
- R1: After reset every slot is empty and every output is 0. Output fields are 0 in any cycle where their valid bit is 0. `req_kind` encodes 0 = read, 1 = write, 2 = evict, 3 = reserved. `grant_state` encodes 1 = Shared, 2 = Exclusive, 3 = Modified. `fwd_write` is 0 for a forwarded read and 1 for a forwarded write.
- R2: A read to an untracked line allocates a slot with only the requester as holder. It issues `mem_rd` for the line and grants Exclusive, with no forward and no supplier.
- R3: A read to a tracked, unmodified line adds the requester to the holders. It grants Shared. If another cache holds the line, the block sends a read forward to the lowest-numbered other holder only, and names that holder as supplier.
- R4: A read to a modified line owned by another cache sends a read forward to the owner and names the owner as supplier. It grants Shared. The line becomes unmodified, with both the owner and the requester as holders.
- R5: A write to an untracked line allocates a slot with only the requester as holder. The slot is marked modified, `mem_rd` is issued and the grant is Modified.
- R6: A write to a tracked, unmodified line sends a write forward to every other holder and names the lowest-numbered one as supplier. The line is left modified, with the requester as its only holder, and the grant is Modified.
- R7: A write to a modified line owned by another cache sends a write forward to the owner and names the owner as supplier. Ownership moves to the requester, and the grant is Modified.
- R8: A request from a cache that is the only holder of a tracked line produces no forward, no supplier and no memory read. A read grants Shared if the line is unmodified and Modified if it is modified. A write grants Modified.
- R9: An evict clears the sender's bit. When no holder remains, the slot becomes free, so the next access to that line is a miss. An evict for an untracked line, or from a cache that holds no copy, changes nothing and produces no output.
- R10: A miss with every slot in use displaces the slot chosen by a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, on each displacement. In that same cycle the block issues `inv` to all holders of the victim, with the victim's address, together with `mem_rd` for the new line.
- R11: A miss while some slot is free takes the lowest-numbered free slot, issues no invalidation and leaves the round-robin pointer unchanged.
- R12: A request with kind 3 is ignored: no output, and no change to any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 evict, 3 reserved |
| req_id | input | ID_W | Requesting cache |
| req_addr | input | ADDR_W | Line address |
| grant_valid | output | 1 | Grant to requester |
| grant_id | output | ID_W | Cache receiving the grant |
| grant_state | output | 2 | 1 Shared, 2 Exclusive, 3 Modified |
| fwd_valid | output | 1 | Forwarded message present |
| fwd_write | output | 1 | 0 read forward, 1 write forward |
| fwd_mask | output | N_CACHE | Caches receiving the forward |
| fwd_addr | output | ADDR_W | Line address of the forward |
| supply_valid | output | 1 | A peer cache supplies the data |
| supply_id | output | ID_W | Supplying cache |
| mem_rd_valid | output | 1 | Read from lower level |
| mem_rd_addr | output | ADDR_W | Address to read |
| inv_valid | output | 1 | Invalidation for a displaced slot |
| inv_mask | output | N_CACHE | Caches to invalidate |
| inv_addr | output | ADDR_W | Address of displaced line |

## Verification
Two functions can fire in the same response cycle: the memory read for a newly allocated line, and the invalidation of the slot that allocation displaces. The bench provokes this by touching more distinct addresses than there are slots. It does so with directed fills and with a long pseudo-random stream over six addresses and four slots. A bench-side table model predicts the victim, its holder vector and the new address, and each response is compared as a whole. A wrong pointer step or a stale mask therefore shows up on the same comparison as the memory read.

// File: rtl/coh_dir_pkg.sv
// Shared encodings for the coherence directory.
// Assumes: the request kind and grant codes are fixed at two bits.
package coh_dir_pkg;
    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_EVICT = 2'd2,
        K_NONE  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        G_NONE   = 2'd0,
        G_SHARED = 2'd1,
        G_EXCL   = 2'd2,
        G_MOD    = 2'd3
    } grant_e;
endpackage

// File: rtl/coh_dir_pick.sv
// Lowest-set-bit finder.
// Returns whether any bit of vec is set and the index of the lowest one.
// Assumes: W >= 2 and IW wide enough for W-1.
module coh_dir_pick #(
    parameter int W  = 4,
    parameter int IW = 2
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/coh_dir_lookup.sv
// Associative tag match over all directory slots.
// Reports the hitting slot and the lowest free slot.
// Assumes: at most one valid slot matches a given address.
module coh_dir_lookup #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 8,
    parameter int IW      = 2
) (
    input  logic [ENTRIES-1:0]             slot_vld,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] slot_addr,
    input  logic [ADDR_W-1:0]              key,
    output logic                           hit,
    output logic [IW-1:0]                  hit_idx,
    output logic                           free_any,
    output logic [IW-1:0]                  free_idx
);
    logic [ENTRIES-1:0] match;

    // One comparator per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = slot_vld[g] && (slot_addr[g] == key);
    end

    coh_dir_pick #(.W(ENTRIES), .IW(IW)) u_hit (
        .vec(match), .found(hit), .idx(hit_idx)
    );

    coh_dir_pick #(.W(ENTRIES), .IW(IW)) u_free (
        .vec(~slot_vld), .found(free_any), .idx(free_idx)
    );
endmodule

// File: rtl/coh_dir_victim.sv
// Round-robin victim pointer over the slots.
// Advances by one, wrapping, each time a displacement happens.
// Assumes: ENTRIES >= 2.
module coh_dir_victim #(
    parameter int ENTRIES = 4,
    parameter int IW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [IW-1:0] ptr
);
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    // Step the pointer on every displacement.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/coh_dir.sv
// Coherence directory: a small associative table of line state and holder
// vectors. It answers each request one cycle later with a grant, forwards,
// a supplier id, a memory read and, on displacement, an invalidation.
// Assumes: one request per cycle; the caches honour forwards; data moves
// outside this block.
module coh_dir #(
    parameter int N_CACHE = 4,
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 8,
    parameter int ID_W    = $clog2(N_CACHE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [ID_W-1:0]    req_id,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               grant_valid,
    output logic [ID_W-1:0]    grant_id,
    output logic [1:0]         grant_state,
    output logic               fwd_valid,
    output logic               fwd_write,
    output logic [N_CACHE-1:0] fwd_mask,
    output logic [ADDR_W-1:0]  fwd_addr,
    output logic               supply_valid,
    output logic [ID_W-1:0]    supply_id,
    output logic               mem_rd_valid,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    output logic               inv_valid,
    output logic [N_CACHE-1:0] inv_mask,
    output logic [ADDR_W-1:0]  inv_addr
);
    import coh_dir_pkg::*;

    localparam int IW = $clog2(ENTRIES);

    // Slot storage.
    logic [ENTRIES-1:0]                   s_vld;
    logic [ENTRIES-1:0]                   s_mod;
    logic [ENTRIES-1:0][ADDR_W-1:0]       s_addr;
    logic [ENTRIES-1:0][N_CACHE-1:0]      s_sh;

    logic          hit, free_any, oth_any, rr_adv;
    logic [IW-1:0] hit_idx, free_idx, rr_ptr;
    logic [ID_W-1:0] oth_idx;
    logic [N_CACHE-1:0] req_bit, hit_sh, others;
    req_kind_e     kind;

    // Next-cycle response and slot write.
    logic               n_gv, n_fv, n_fw, n_sv, n_mv, n_iv;
    logic [1:0]         n_gs;
    logic [N_CACHE-1:0] n_fm, n_im;
    logic [ID_W-1:0]    n_sid;
    logic [ADDR_W-1:0]  n_ia;
    logic               w_en, w_vld, w_mod;
    logic [IW-1:0]      w_idx;
    logic [N_CACHE-1:0] w_sh;

    coh_dir_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IW(IW)) u_look (
        .slot_vld(s_vld), .slot_addr(s_addr), .key(req_addr),
        .hit(hit), .hit_idx(hit_idx), .free_any(free_any), .free_idx(free_idx)
    );

    coh_dir_pick #(.W(N_CACHE), .IW(ID_W)) u_oth (
        .vec(others), .found(oth_any), .idx(oth_idx)
    );

    coh_dir_victim #(.ENTRIES(ENTRIES), .IW(IW)) u_rr (
        .clk(clk), .rst_n(rst_n), .advance(rr_adv), .ptr(rr_ptr)
    );

    // Holder views of the addressed slot.
    assign kind    = req_kind_e'(req_kind);
    assign req_bit = N_CACHE'(1) << req_id;
    assign hit_sh  = s_sh[hit_idx];
    assign others  = hit ? (hit_sh & ~req_bit) : '0;

    // Protocol decision for the current request.
    always_comb begin
        n_gv = 1'b0; n_gs = G_NONE; n_fv = 1'b0; n_fw = 1'b0; n_fm = '0;
        n_sv = 1'b0; n_sid = '0; n_mv = 1'b0; n_iv = 1'b0; n_im = '0; n_ia = '0;
        w_en = 1'b0; w_idx = hit_idx; w_vld = 1'b1; w_mod = 1'b0; w_sh = '0;
        rr_adv = 1'b0;
        if (req_valid && (kind == K_READ || kind == K_WRITE)) begin
            n_gv = 1'b1;
            w_en = 1'b1;
            if (!hit) begin
                n_mv  = 1'b1;
                w_idx = free_any ? free_idx : rr_ptr;
                w_sh  = req_bit;
                w_mod = (kind == K_WRITE);
                n_gs  = (kind == K_WRITE) ? G_MOD : G_EXCL;
                if (!free_any) begin
                    rr_adv = 1'b1;
                    n_iv   = 1'b1;
                    n_im   = s_sh[rr_ptr];
                    n_ia   = s_addr[rr_ptr];
                end
            end else if (kind == K_WRITE) begin
                w_sh  = req_bit;
                w_mod = 1'b1;
                n_gs  = G_MOD;
                if (oth_any) begin
                    n_fv = 1'b1; n_fw = 1'b1; n_fm = others;
                    n_sv = 1'b1; n_sid = oth_idx;
                end
            end else begin
                w_sh = hit_sh | req_bit;
                if (s_mod[hit_idx] && !oth_any) begin
                    w_mod = 1'b1;
                    n_gs  = G_MOD;
                end else begin
                    n_gs = G_SHARED;
                    if (oth_any) begin
                        n_fv = 1'b1;
                        n_fm = N_CACHE'(1) << oth_idx;
                        n_sv = 1'b1; n_sid = oth_idx;
                    end
                end
            end
        end else if (req_valid && kind == K_EVICT && hit && hit_sh[req_id]) begin
            w_en  = 1'b1;
            w_sh  = others;
            w_vld = |others;
            w_mod = s_mod[hit_idx] && (|others);
        end
    end

    // Slot update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_vld <= '0; s_mod <= '0; s_addr <= '0; s_sh <= '0;
        end else if (w_en) begin
            s_vld[w_idx]  <= w_vld;
            s_mod[w_idx]  <= w_mod;
            s_addr[w_idx] <= req_addr;
            s_sh[w_idx]   <= w_sh;
        end
    end

    // Registered response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0; grant_id <= '0; grant_state <= '0;
            fwd_valid <= 1'b0; fwd_write <= 1'b0; fwd_mask <= '0; fwd_addr <= '0;
            supply_valid <= 1'b0; supply_id <= '0;
            mem_rd_valid <= 1'b0; mem_rd_addr <= '0;
            inv_valid <= 1'b0; inv_mask <= '0; inv_addr <= '0;
        end else begin
            grant_valid  <= n_gv;
            grant_id     <= n_gv ? req_id : '0;
            grant_state  <= n_gs;
            fwd_valid    <= n_fv;
            fwd_write    <= n_fw;
            fwd_mask     <= n_fm;
            fwd_addr     <= n_fv ? req_addr : '0;
            supply_valid <= n_sv;
            supply_id    <= n_sid;
            mem_rd_valid <= n_mv;
            mem_rd_addr  <= n_mv ? req_addr : '0;
            inv_valid    <= n_iv;
            inv_mask     <= n_im;
            inv_addr     <= n_ia;
        end
    end
endmodule

// File: rtl/coh_dir_chk.sv
// Protocol checker for coh_dir, attached by bind.
// Assumes: the port encodings of coh_dir_pkg.
module coh_dir_chk #(
    parameter int N_CACHE = 4,
    parameter int ID_W    = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [1:0]         req_kind,
    input logic               grant_valid,
    input logic [1:0]         grant_state,
    input logic               fwd_valid,
    input logic               fwd_write,
    input logic [N_CACHE-1:0] fwd_mask,
    input logic               supply_valid,
    input logic [ID_W-1:0]    supply_id,
    input logic               mem_rd_valid,
    input logic               inv_valid
);
    AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !grant_valid && !fwd_valid && !mem_rd_valid); // R1
    AST_MEM_EXCLUDES_PEER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !fwd_valid && !supply_valid); // R2
    AST_READ_FWD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_write) |-> $countones(fwd_mask) == 1); // R3
    AST_SUPPLIER_TARGETED: assert property (@(posedge clk) disable iff (!rst_n)
        supply_valid |-> fwd_valid && fwd_mask[supply_id]); // R4
    AST_WRITE_FWD_GRANTS_M: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_write) |-> grant_valid && grant_state == 2'd3); // R6
    AST_EVICT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_kind == 2'd2) |-> !grant_valid && !fwd_valid && !inv_valid); // R9
    AST_INV_WITH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> mem_rd_valid && grant_valid); // R10
endmodule

bind coh_dir coh_dir_chk #(.N_CACHE(N_CACHE), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .grant_valid(grant_valid), .grant_state(grant_state),
    .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_mask(fwd_mask),
    .supply_valid(supply_valid), .supply_id(supply_id),
    .mem_rd_valid(mem_rd_valid), .inv_valid(inv_valid)
);

// File: tb/sim_coh_dir.sv
// Bench for coh_dir: a table model predicts every response; directed
// corner cases, then a long pseudo-random stream over six addresses.
module sim_coh_dir;
    localparam int N = 4, E = 4, AW = 8, IDW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic [IDW-1:0] req_id = '0;
    logic [AW-1:0] req_addr = '0;
    logic gv, fv, fw, sv, mv, iv;
    logic [IDW-1:0] gid, sid;
    logic [1:0] gs;
    logic [N-1:0] fm, im;
    logic [AW-1:0] fa, ma, ia;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    coh_dir #(.N_CACHE(N), .ENTRIES(E), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_id(req_id), .req_addr(req_addr),
        .grant_valid(gv), .grant_id(gid), .grant_state(gs),
        .fwd_valid(fv), .fwd_write(fw), .fwd_mask(fm), .fwd_addr(fa),
        .supply_valid(sv), .supply_id(sid),
        .mem_rd_valid(mv), .mem_rd_addr(ma),
        .inv_valid(iv), .inv_mask(im), .inv_addr(ia)
    );

    // Model state.
    bit       m_vld[E];
    bit       m_mod[E];
    int       m_addr[E];
    bit [N-1:0] m_sh[E];
    int       m_rr = 0;
    logic [43:0] exp_v;
    string    tag;

    function automatic logic [43:0] pack(bit g, int gi, int gst, bit f, bit fwr,
            int fmask, int faddr, bit s, int si, bit m, int maddr,
            bit i, int imask, int iaddr);
        return {g, 2'(gi), 2'(gst), f, fwr, 4'(fmask), 8'(faddr), s, 2'(si),
                m, 8'(maddr), i, 4'(imask), 8'(iaddr)};
    endfunction

    // Predict the response from the requirements and update the model.
    task automatic model(int k, int id, int a);
        int h = -1, fr = -1, lo = -1, slot;
        bit [N-1:0] rb, oth;
        rb = N'(1) << id;
        for (int e = E - 1; e >= 0; e--) begin
            if (m_vld[e] && m_addr[e] == a) h = e;
            if (!m_vld[e]) fr = e;
        end
        oth = (h >= 0) ? (m_sh[h] & ~rb) : '0;
        for (int c = N - 1; c >= 0; c--) if (oth[c]) lo = c;
        exp_v = '0;
        if (k == 3) begin
            tag = "R12";
        end else if (k == 2) begin
            tag = "R9";
            if (h >= 0 && m_sh[h][id]) begin
                m_sh[h] = oth;
                if (oth == 0) begin m_vld[h] = 0; m_mod[h] = 0; end
            end
        end else if (h < 0) begin
            tag = (k == 1) ? "R5" : "R2";
            if (fr >= 0) begin
                slot = fr;
                tag = {tag, "/R11"};
                exp_v = pack(1, id, k == 1 ? 3 : 2, 0, 0, 0, 0, 0, 0, 1, a, 0, 0, 0);
            end else begin
                slot = m_rr;
                tag = {tag, "/R10"};
                exp_v = pack(1, id, k == 1 ? 3 : 2, 0, 0, 0, 0, 0, 0, 1, a,
                             1, m_sh[slot], m_addr[slot]);
                m_rr = (m_rr + 1) % E;
            end
            m_vld[slot] = 1; m_mod[slot] = (k == 1); m_addr[slot] = a; m_sh[slot] = rb;
        end else if (k == 1) begin
            if (lo < 0) begin
                tag = "R8";
                exp_v = pack(1, id, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            end else begin
                tag = m_mod[h] ? "R7" : "R6";
                exp_v = pack(1, id, 3, 1, 1, oth, a, 1, lo, 0, 0, 0, 0, 0);
            end
            m_sh[h] = rb; m_mod[h] = 1;
        end else begin
            if (lo < 0) begin
                tag = "R8";
                exp_v = pack(1, id, m_mod[h] ? 3 : 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            end else begin
                tag = m_mod[h] ? "R4" : "R3";
                exp_v = pack(1, id, 1, 1, 0, 1 << lo, a, 1, lo, 0, 0, 0, 0, 0);
                m_mod[h] = 0;
            end
            m_sh[h] = m_sh[h] | rb;
        end
    endtask

    // Issue one request and compare the response one cycle later.
    task automatic req(int k, int id, int a);
        model(k, id, a);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(k); req_id = IDW'(id); req_addr = AW'(a);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        checks++;
        if ({gv, gid, gs, fv, fw, fm, fa, sv, sid, mv, ma, iv, im, ia} !== exp_v) begin
            errors++;
            $display("FAIL %s kind=%0d id=%0d addr=%0d actual=%h expected=%h",
                     tag, k, id, a,
                     {gv, gid, gs, fv, fw, fm, fa, sv, sid, mv, ma, iv, im, ia}, exp_v);
        end
    endtask

    initial begin : watchdog
        #1500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] lf;
        for (int e = 0; e < E; e++) begin
            m_vld[e] = 0; m_mod[e] = 0; m_addr[e] = 0; m_sh[e] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++; // R1 reset state
        if ({gv, fv, sv, mv, iv, fm, im} !== '0) begin
            errors++;
            $display("FAIL R1 outputs after reset actual=%b expected=0",
                     {gv, fv, sv, mv, iv, fm, im});
        end
        // Directed corner cases.
        req(0, 1, 10);  // R2 miss read, slot 0
        req(0, 3, 10);  // R3 forward to holder 1
        req(0, 0, 10);  // R3 lowest other holder is 1
        req(0, 1, 10);  // R3 requester already holds
        req(1, 2, 10);  // R6 write forward to 0,1,3
        req(0, 2, 10);  // R8 sole owner reads, grant M
        req(1, 2, 10);  // R8 sole owner writes
        req(1, 0, 10);  // R7 owner 2 forwards
        req(0, 3, 10);  // R4 owner 0 supplies, becomes shared
        req(1, 1, 20);  // R5 miss write
        req(2, 2, 20);  // R9 evict by non-holder ignored
        req(2, 1, 20);  // R9 evict last holder frees slot
        req(0, 2, 20);  // R11 lowest free slot reused
        req(3, 0, 10);  // R12 reserved kind ignored
        req(2, 0, 30);  // R9 evict of untracked line
        req(0, 1, 30);  // R11
        req(1, 3, 40);  // R11 fills last slot
        req(0, 2, 50);  // R10 displace slot 0
        req(0, 2, 60);  // R10 displace slot 1
        req(0, 0, 10);  // R10 line 10 was displaced
        // Pseudo-random sweep over six addresses, four caches.
        lf = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            req((lf[1:0] == 2'd3) ? ((n % 7 == 0) ? 3 : 0) : int'(lf[1:0]),
                int'(lf[9:8]), int'(lf[6:4]) % 6);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule